// File: doc/BRIEF.md
# Layered Configurable Gate Array

This block is a feed-forward fabric of configurable logic gates. There are eight layers of sixteen gates. A single wide configuration word, held in one register, sets the behaviour of every gate. Each gate takes three operands from the sixteen outputs of the layer before it and applies one of four functions. The first layer draws on the eight primary inputs and their complements. The first eight gates of the last layer drive the eight primary outputs.

A search engine outside the block writes a candidate configuration through a parallel load port. It then applies input vectors and scores the outputs. Apart from the configuration register, the path from inputs to outputs has no storage, so any new input vector is reflected at the outputs within the same cycle. The path has no feedback.

Top module: `cfg_gate_array`

## Requirements
- R1: Reset (rst_n low) clears the configuration register to all zeros. With an all-zero configuration, every output bit equals data_in[0].
- R2: When cfg_we is high at a rising clock edge, cfg_bits is captured whole. The new configuration governs data_out from that edge onward.
- R3: While cfg_we is low, cfg_bits is ignored and the configuration is held.
- R4: Layers and gates are numbered from 0. The gene of gate g in layer L occupies bits [(L*16+g)*14 +: 14]. Within a gene, selector A is bits 3:0, selector B is bits 7:4, selector C is bits 11:8 and the function code is bits 13:12.
- R5: The function codes are: 00 passes operand A; 01 gives A AND B; 10 gives A XOR B; 11 gives B when C is 1 and A otherwise.
- R6: In layer 0, source index i (0 to 7) is data_in[i] and source index i (8 to 15) is the complement of data_in[i-8]. In every later layer, source index i is the output of gate i of the previous layer.
- R7: data_out[k] is the output of gate k (0 to 7) of the last layer.
- R8: data_out depends combinationally on data_in. It follows a change of data_in within the same cycle and stays stable while both data_in and the configuration are stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the configuration |
| cfg_bits | input | 1792 | Full configuration word |
| data_in | input | 8 | Primary inputs |
| data_out | output | 8 | Primary outputs |

## Verification
Hand-built configurations isolate one feature each:
- A straight buffer chain shows that sources map to outputs one to one.
- Selecting the complemented sources separates indices 8 to 15 from indices 0 to 7.
- Single AND, XOR and multiplexer stages, each placed in a different layer, tell the function codes apart.
- Rotated operand choices show that the selectors are not swapped.

Random configurations, each tried with several input vectors, are compared against a behavioural model on every clock. This exercises the gene packing over all layers. Separate checks confirm that input changes pass through without a clock edge and that cfg_bits has no effect while the strobe is low.

// File: rtl/cga_pkg.sv
package cga_pkg;
  typedef enum logic [1:0] {
    FN_PASS = 2'b00,
    FN_AND  = 2'b01,
    FN_XOR  = 2'b10,
    FN_MUX  = 2'b11
  } gate_fn_e;

  // R5: gate function applied to the three selected operands
  function automatic logic gate_eval(input gate_fn_e fn, input logic a,
                                     input logic b, input logic c);
    logic r;
    case (fn)
      FN_PASS: r = a;
      FN_AND:  r = a & b;
      FN_XOR:  r = a ^ b;
      default: r = c ? b : a;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cga_gate.sv
module cga_gate #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned SEL_W = $clog2(N_SRC),
  parameter int unsigned GENE_W = 3 * SEL_W + 2
) (
  input  logic [GENE_W-1:0] gene,
  input  logic [N_SRC-1:0]  src,
  output logic              y
);
  import cga_pkg::*;

  logic [SEL_W-1:0] sel_a, sel_b, sel_c;
  gate_fn_e         fn;

  // R4: field layout inside one gene
  assign sel_a = gene[SEL_W-1:0];
  assign sel_b = gene[2*SEL_W-1:SEL_W];
  assign sel_c = gene[3*SEL_W-1:2*SEL_W];
  assign fn    = gate_fn_e'(gene[GENE_W-1:3*SEL_W]);

  assign y = gate_eval(fn, src[sel_a], src[sel_b], src[sel_c]);
endmodule

// File: rtl/cga_layer.sv
module cga_layer #(
  parameter int unsigned N_GATES = 16,
  parameter int unsigned SEL_W = $clog2(N_GATES),
  parameter int unsigned GENE_W = 3 * SEL_W + 2,
  localparam int unsigned LAYER_W = N_GATES * GENE_W
) (
  input  logic [LAYER_W-1:0] genes,
  input  logic [N_GATES-1:0] src,
  output logic [N_GATES-1:0] dst
);
  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    cga_gate #(
      .N_SRC (N_GATES),
      .SEL_W (SEL_W),
      .GENE_W(GENE_W)
    ) u_gate (
      .gene(genes[g*GENE_W +: GENE_W]),
      .src (src),
      .y   (dst[g])
    );
  end
endmodule

// File: rtl/cga_cfg_reg.sv
module cga_cfg_reg #(
  parameter int unsigned WIDTH = 1792
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // R1, R2, R3
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/cfg_gate_array.sv
module cfg_gate_array #(
  parameter int unsigned N_IN = 8,
  parameter int unsigned N_LAYERS = 8,
  parameter int unsigned N_GATES = 2 * N_IN,
  localparam int unsigned SEL_W = $clog2(N_GATES),
  localparam int unsigned GENE_W = 3 * SEL_W + 2,
  localparam int unsigned LAYER_W = N_GATES * GENE_W,
  localparam int unsigned CFG_W = N_LAYERS * LAYER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_bits,
  input  logic [N_IN-1:0]  data_in,
  output logic [N_IN-1:0]  data_out
);
  logic [CFG_W-1:0]   chromo_q;
  logic [N_GATES-1:0] stage [N_LAYERS+1];
  logic [N_GATES-1:0] l0_out;
  logic               unused_upper;

  cga_cfg_reg #(.WIDTH(CFG_W)) u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .d    (cfg_bits),
    .q    (chromo_q)
  );

  // R6: first layer sees true inputs then complements
  assign stage[0] = {~data_in, data_in};

  for (genvar l = 0; l < N_LAYERS; l++) begin : g_layer
    cga_layer #(
      .N_GATES(N_GATES),
      .SEL_W  (SEL_W),
      .GENE_W (GENE_W)
    ) u_layer (
      .genes(chromo_q[l*LAYER_W +: LAYER_W]),
      .src  (stage[l]),
      .dst  (stage[l+1])
    );
  end

  assign l0_out = stage[1];

  // R7: low gates of the final layer drive the outputs
  assign data_out     = stage[N_LAYERS][N_IN-1:0];
  assign unused_upper = ^stage[N_LAYERS][N_GATES-1:N_IN];
endmodule

// File: rtl/cfg_gate_array_chk.sv
module cfg_gate_array_chk #(
  parameter int unsigned N_IN = 8,
  parameter int unsigned N_GATES = 16,
  parameter int unsigned CFG_W = 1792
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_bits,
  input logic [N_IN-1:0]  data_in,
  input logic [N_IN-1:0]  data_out,
  input logic [CFG_W-1:0] chromo_q,
  input logic [N_GATES-1:0] l0_out
);
  localparam int unsigned SEL_W = $clog2(N_GATES);

  logic [SEL_W-1:0] g0_sel;
  logic [1:0]       g0_fn;
  logic             g0_expect;
  int               g0_idx;

  assign g0_sel = chromo_q[SEL_W-1:0];
  assign g0_fn  = chromo_q[3*SEL_W+1:3*SEL_W];
  assign g0_idx = int'(g0_sel);

  always_comb begin
    if (g0_idx < int'(N_IN)) g0_expect = data_in[g0_idx];
    else                     g0_expect = ~data_in[g0_idx - int'(N_IN)];
  end

  a_r1_zero_cfg_copies_in0: assert property (@(posedge clk) disable iff (!rst_n)
    (chromo_q == '0) |-> (data_out == {N_IN{data_in[0]}}));

  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (chromo_q == $past(cfg_bits)));

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(chromo_q));

  a_r6_first_gate_source: assert property (@(posedge clk) disable iff (!rst_n)
    (g0_fn == 2'b00) |-> (l0_out[0] == g0_expect));

  a_r8_stable_out: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(chromo_q) && $stable(data_in)) |-> $stable(data_out));
endmodule

bind cfg_gate_array cfg_gate_array_chk #(
  .N_IN   (N_IN),
  .N_GATES(N_GATES),
  .CFG_W  (CFG_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_we  (cfg_we),
  .cfg_bits(cfg_bits),
  .data_in (data_in),
  .data_out(data_out),
  .chromo_q(chromo_q),
  .l0_out  (l0_out)
);

// File: tb/cfg_gate_array_bench.sv
module cfg_gate_array_bench;
  localparam int CW = 1792;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_bits = '0;
  logic [7:0]    data_in = '0;
  logic [7:0]    data_out;

  logic [CW-1:0] model_c = '0;
  logic [CW-1:0] build_c;
  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_gate_array u_cfg_gate_array (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bits(cfg_bits),
    .data_in(data_in), .data_out(data_out)
  );

  // Behavioural model: R4 packing, R5 functions, R6 sources, R7 outputs
  function automatic logic [7:0] ref_eval(input logic [CW-1:0] c, input logic [7:0] x);
    logic [15:0] prv, cur;
    prv = {~x, x};
    for (int l = 0; l < 8; l++) begin
      for (int g = 0; g < 16; g++) begin
        int base;
        logic a, b, s;
        base = (l * 16 + g) * 14;
        a = prv[c[base +: 4]];
        b = prv[c[base + 4 +: 4]];
        s = prv[c[base + 8 +: 4]];
        case (c[base + 12 +: 2])
          2'd0: cur[g] = a;
          2'd1: cur[g] = a & b;
          2'd2: cur[g] = a ^ b;
          default: cur[g] = s ? b : a;
        endcase
      end
      prv = cur;
    end
    return prv[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: data_out=%h expected=%h (in=%h)", req, got, exp, data_in);
    end
  endtask

  // Compare with the model on every clock
  always @(negedge clk) begin
    if (live) check("R5 per-clock model", data_out, ref_eval(model_c, data_in));
  end

  task automatic put_gene(input int l, input int g, input int sa, input int sb,
                          input int sc, input int fn);
    build_c[(l * 16 + g) * 14 +: 14] = {fn[1:0], sc[3:0], sb[3:0], sa[3:0]};
  endtask

  task automatic chain_all();
    build_c = '0;
    for (int l = 0; l < 8; l++)
      for (int g = 0; g < 16; g++) put_gene(l, g, g, 0, 0, 0);
  endtask

  task automatic load(input logic [CW-1:0] v);
    @(posedge clk); #1;
    cfg_bits = v; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    model_c = v;
  endtask

  task automatic apply(input logic [7:0] x);
    @(posedge clk); #1;
    data_in = x;
    #1;
  endtask

  function automatic logic [7:0] rot1(input logic [7:0] x);
    return {x[0], x[7:1]};
  endfunction

  initial begin
    logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    live = 1'b1;

    // R1: zero configuration after reset
    apply(8'h01); check("R1 reset state", data_out, 8'hFF);
    apply(8'hFE); check("R1 reset state", data_out, 8'h00);

    // R2, R6, R7: straight chain of pass gates
    chain_all(); load(build_c);
    foreach (pats[i]) begin apply(pats[i]); check("R2 R7 pass chain", data_out, pats[i]); end

    // R6: complemented sources in layer 0
    chain_all();
    for (int g = 0; g < 8; g++) put_gene(0, g, 8 + g, 0, 0, 0);
    load(build_c);
    foreach (pats[i]) begin apply(pats[i]); check("R6 complement sources", data_out, ~pats[i]); end

    // R5: AND in layer 0
    chain_all();
    for (int g = 0; g < 8; g++) put_gene(0, g, g, (g + 1) % 8, 0, 1);
    load(build_c);
    foreach (pats[i]) begin apply(pats[i]); check("R5 AND code", data_out, pats[i] & rot1(pats[i])); end

    // R5: XOR in layer 4
    chain_all();
    for (int g = 0; g < 8; g++) put_gene(4, g, g, (g + 1) % 8, 0, 2);
    load(build_c);
    foreach (pats[i]) begin apply(pats[i]); check("R5 XOR code", data_out, pats[i] ^ rot1(pats[i])); end

    // R5: MUX in the last layer, C from gate 0, B from complement chain
    chain_all();
    for (int g = 0; g < 8; g++) put_gene(7, g, g, 8 + g, 0, 3);
    load(build_c);
    foreach (pats[i]) begin
      apply(pats[i]);
      check("R5 MUX code", data_out, pats[i][0] ? ~pats[i] : pats[i]);
    end

    // R8: same-cycle response, no clock edge between change and sample
    @(posedge clk); #1 data_in = 8'h0F; #1;
    check("R8 combinational", data_out, 8'hF0);
    data_in = 8'hF0; #1;
    check("R8 combinational", data_out, 8'hF0);

    // R3: strobe low, new cfg_bits ignored
    @(posedge clk); #1 cfg_bits = '1;
    repeat (3) @(posedge clk);
    #1 data_in = 8'h5A; #1;
    check("R3 hold while idle", data_out, 8'h5A);

    // R4: random configurations against the model
    for (int t = 0; t < 20; t++) begin
      for (int w = 0; w < CW / 32; w++) build_c[w * 32 +: 32] = $urandom;
      load(build_c);
      for (int k = 0; k < 6; k++) begin
        logic [7:0] x;
        x = 8'($urandom);
        apply(x);
        check("R4 random packing", data_out, ref_eval(build_c, x));
      end
    end

    // R1: reset again clears configuration
    @(posedge clk); #1 rst_n = 1'b0; live = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1; model_c = '0; live = 1'b1;
    apply(8'h01); check("R1 reset clears", data_out, 8'hFF);

    live = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule